// File: doc/BRIEF.md
# Serial Flash Transaction Engine

This block runs one serial flash transaction at a time, as composed by software through a small 32-bit register window. A transaction can have an optional opcode byte, 0 to 4 address bytes, 0 to 7 dummy bytes, and up to 16 bytes sent to the flash followed by up to 16 bytes received from it. Each phase has its own lane width of one, two or four data lines. The engine produces the serial clock, drives one of four active-low chip selects, and drives or samples four data lines. A separate output-enable per line goes to the pad.

Software loads the configuration, opcode, address and outgoing bytes. It writes the start bit and then polls the busy bit, or waits for the ready interrupt. Received bytes then appear in the read-data words. Software can keep the chip select asserted after a run ends. Several runs then form one long flash operation, for example a page program streamed in 16-byte pieces. A later register write releases the chip select.

Top module: `flash_xact_engine`

## Requirements
- R1: After reset all chip selects are high, SCLK is low, every output enable is 0, irq is 0, and the control word reads 0x0001_0000 (chip-select release bit set, all other bits clear).
- R2: Register offsets are: config 0x08, control 0x0C, opcode 0x10, address 0x14, outgoing data words 0x20–0x2C and received data words 0x30–0x3C. Writing 1 to control bit 0 while idle starts a run. Bit 0 reads 1 until the run ends, then reads 0, and ready (bit 24) becomes 1. Writing 1 to bit 24 clears ready.
- R3: Phases run in this order: opcode, address, dummy, send, receive. A phase whose byte count is zero is skipped. Config bit 10 enables the opcode byte. The address count is in bits [13:11] and is clamped to 4. The dummy count is in [23:21]. The send count is in [20:16] and the receive count in [28:24], both clamped to 16. With all counts zero, a run ends without any SCLK pulse.
- R4: Each phase has a 2-bit lane code: opcode [1:0], address [3:2], send [5:4], dummy [7:6], receive [9:8]. Code 0 means one line: drive io 0 and sample io 1. Code 1 means two lines on io[1:0], and code 2 or 3 means four lines on io[3:0]. Every byte goes out MSB first, and the highest-numbered lane carries the most significant bit of each slice.
- R5: SCLK idles low (mode 0). Each SCLK period is two system clocks. Outputs change only while SCLK is low, and input lines are sampled at the rising edge.
- R6: The address phase sends the low N bytes of the address register, most significant first, where N is the clamped address count. The opcode byte comes from opcode register bits [7:0].
- R7: Data bytes are packed little-endian. Byte k lives in word k/4, bits 8*(k%4)+7..8*(k%4). When a run ends, all four received words are replaced, and bytes not received read as zero.
- R8: During dummy and receive phases all output enables are 0. Each dummy byte lasts 8/lanes SCLK periods, and io_out is 0 whenever a line is not driven.
- R9: Control bits [9:8] select the chip select. At most one chip select is ever low, and the selected one is low for the whole run. If control bit 16 is 0, it stays low after the run ends. Writing bit 16 as 1 releases it.
- R10: While a run is busy, a start write has no effect. Writes to config, opcode, address, outgoing data and the chip-select field are also ignored.
- R11: The received data words keep their previous contents while a run is busy and change only when the run ends.
- R12: irq is 1 exactly when ready (bit 24) and the interrupt enable (control bit 25) are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when 1, read when 0 |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational from bus_addr) |
| irq | output | 1 | Ready interrupt |
| sclk | output | 1 | Serial clock |
| cs_n | output | NUM_CS | Active-low chip selects |
| io_out | output | 4 | Data line output values |
| io_oe | output | 4 | Data line output enables |
| io_in | input | 4 | Data line input values |

## Verification
The bench builds the block with its default parameters: four chip selects, a 16-byte data window and an 8-bit register offset. At this size the largest run lasts only a few hundred SCLK periods, so a sweep can cover every lane code for every phase. The sweep also covers every address count including the clamped one, and send and receive counts from 0 up past the 16-byte clamp, each combined with varied dummy counts and chip selects. A flash model on the pins records each rising edge and returns a position-derived pattern. This lets every run's edge count, lane stream, clock period and received words be checked exactly, and leaves room for directed runs on busy-time writes, chip-select hold and the interrupt.

// File: rtl/fxe_pkg.sv
package fxe_pkg;

  typedef enum logic [2:0] {
    PH_CMD   = 3'd0,
    PH_ADDR  = 3'd1,
    PH_DUMMY = 3'd2,
    PH_WR    = 3'd3,
    PH_RD    = 3'd4,
    PH_END   = 3'd5
  } phase_e;

  localparam logic [7:0] OFF_CFG  = 8'h08;
  localparam logic [7:0] OFF_CTL  = 8'h0C;
  localparam logic [7:0] OFF_CMD  = 8'h10;
  localparam logic [7:0] OFF_ADDR = 8'h14;

  // Number of byte slots (SCLK periods) per byte for a lane code.
  function automatic logic [3:0] slots_of(input logic [1:0] code);
    case (code)
      2'd0:    return 4'd8;
      2'd1:    return 4'd4;
      default: return 4'd2;
    endcase
  endfunction

  function automatic logic [3:0] lane_mask(input logic [1:0] code);
    case (code)
      2'd0:    return 4'b0001;
      2'd1:    return 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  // Slice of a byte driven in a given slot, MSB first.
  function automatic logic [3:0] lane_bits(input logic [7:0] b, input logic [1:0] code,
                                           input logic [2:0] slot);
    logic [7:0] t;
    case (code)
      2'd0: begin
        t = b << slot;
        return {3'b000, t[7]};
      end
      2'd1: begin
        t = b << {slot[1:0], 1'b0};
        return {2'b00, t[7:6]};
      end
      default: begin
        t = b << {slot[0], 2'b00};
        return t[7:4];
      end
    endcase
  endfunction

  // Shift sampled lines into a partially received byte.
  function automatic logic [7:0] rx_merge(input logic [7:0] cur, input logic [1:0] code,
                                          input logic [3:0] lines);
    case (code)
      2'd0:    return {cur[6:0], lines[1]};
      2'd1:    return {cur[5:0], lines[1:0]};
      default: return {cur[3:0], lines};
    endcase
  endfunction

  function automatic logic [1:0] phase_code(input phase_e ph, input logic [28:0] cfg);
    case (ph)
      PH_CMD:   return cfg[1:0];
      PH_ADDR:  return cfg[3:2];
      PH_WR:    return cfg[5:4];
      PH_DUMMY: return cfg[7:6];
      PH_RD:    return cfg[9:8];
      default:  return 2'd0;
    endcase
  endfunction

  function automatic logic [4:0] phase_len(input phase_e ph, input logic [28:0] cfg,
                                           input logic [4:0] maxd);
    case (ph)
      PH_CMD:   return {4'd0, cfg[10]};
      PH_ADDR:  return (cfg[13:11] > 3'd4) ? 5'd4 : {2'b00, cfg[13:11]};
      PH_DUMMY: return {2'b00, cfg[23:21]};
      PH_WR:    return (cfg[20:16] > maxd) ? maxd : cfg[20:16];
      PH_RD:    return (cfg[28:24] > maxd) ? maxd : cfg[28:24];
      default:  return 5'd0;
    endcase
  endfunction

  // First non-empty phase at or after position 'from'.
  function automatic phase_e find_phase(input int from, input logic [28:0] cfg,
                                        input logic [4:0] maxd);
    phase_e r;
    r = PH_END;
    for (int p = 4; p >= 0; p--) begin
      if (p >= from && phase_len(phase_e'(3'(p)), cfg, maxd) != 5'd0)
        r = phase_e'(3'(p));
    end
    return r;
  endfunction

endpackage

// File: rtl/fxe_regs.sv
module fxe_regs
  import fxe_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int NUM_CS     = 4,
  parameter int DATA_BYTES = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_sel,
  input  logic                      bus_we,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [31:0]               bus_wdata,
  output logic [31:0]               bus_rdata,
  input  logic                      done,
  input  logic [8*DATA_BYTES-1:0]   rx_data,
  output logic [28:0]               cfg,
  output logic [7:0]                cmd,
  output logic [31:0]               addr,
  output logic [8*DATA_BYTES-1:0]   wdata,
  output logic [$clog2(NUM_CS)-1:0] cs_sel,
  output logic                      cs_release,
  output logic                      busy,
  output logic                      go,
  output logic                      start_req,
  output logic                      rdy_flag,
  output logic                      irq
);
  localparam int CS_W       = $clog2(NUM_CS);
  localparam int DATA_WORDS = DATA_BYTES / 4;
  localparam int WI_W       = $clog2(DATA_WORDS);
  localparam int HI_W       = ADDR_W - 4;

  logic                    wr_en;
  logic                    hit_cfg, hit_ctl, hit_cmd, hit_addr, hit_wd, in_rd;
  logic [WI_W-1:0]         widx;
  logic                    irq_en;
  logic [8*DATA_BYTES-1:0] rdata_q;

  assign wr_en    = bus_sel && bus_we;
  assign widx     = bus_addr[2 +: WI_W];
  assign hit_cfg  = wr_en && (bus_addr == ADDR_W'(OFF_CFG));
  assign hit_ctl  = wr_en && (bus_addr == ADDR_W'(OFF_CTL));
  assign hit_cmd  = wr_en && (bus_addr == ADDR_W'(OFF_CMD));
  assign hit_addr = wr_en && (bus_addr == ADDR_W'(OFF_ADDR));
  assign hit_wd   = wr_en && (bus_addr[ADDR_W-1:4] == HI_W'(2));
  assign in_rd    = (bus_addr[ADDR_W-1:4] == HI_W'(3));

  assign start_req = hit_ctl && bus_wdata[0];
  assign go        = start_req && !busy;
  assign irq       = rdy_flag && irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg        <= '0;
      cmd        <= '0;
      addr       <= '0;
      cs_sel     <= '0;
      cs_release <= 1'b1;
      irq_en     <= 1'b0;
      rdy_flag   <= 1'b0;
      busy       <= 1'b0;
      rdata_q    <= '0;
    end else begin
      if (hit_cfg && !busy)  cfg  <= bus_wdata[28:0];
      if (hit_cmd && !busy)  cmd  <= bus_wdata[7:0];
      if (hit_addr && !busy) addr <= bus_wdata;
      if (hit_ctl) begin
        if (!busy) cs_sel <= bus_wdata[8 +: CS_W];
        cs_release <= bus_wdata[16];
        irq_en     <= bus_wdata[25];
      end
      if (done)                            rdy_flag <= 1'b1;
      else if (hit_ctl && bus_wdata[24])   rdy_flag <= 1'b0;
      if (go)        busy <= 1'b1;
      else if (done) busy <= 1'b0;
      if (done) rdata_q <= rx_data;
    end
  end

  for (genvar i = 0; i < DATA_WORDS; i++) begin : g_wd
    logic [31:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q <= '0;
      else if (hit_wd && !busy && widx == WI_W'(i)) word_q <= bus_wdata;
    end
    assign wdata[32*i +: 32] = word_q;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(OFF_CFG))       bus_rdata = {3'b000, cfg};
    else if (bus_addr == ADDR_W'(OFF_CTL)) begin
      bus_rdata[0]         = busy;
      bus_rdata[8 +: CS_W] = cs_sel;
      bus_rdata[16]        = cs_release;
      bus_rdata[24]        = rdy_flag;
      bus_rdata[25]        = irq_en;
    end
    else if (bus_addr == ADDR_W'(OFF_CMD))  bus_rdata = {24'd0, cmd};
    else if (bus_addr == ADDR_W'(OFF_ADDR)) bus_rdata = addr;
    else if (bus_addr[ADDR_W-1:4] == HI_W'(2)) bus_rdata = wdata[{widx, 5'b00000} +: 32];
    else if (in_rd)                            bus_rdata = rdata_q[{widx, 5'b00000} +: 32];
  end

endmodule

// File: rtl/fxe_seq.sv
module fxe_seq
  import fxe_pkg::*;
#(
  parameter int DATA_BYTES = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    go,
  input  logic [28:0]             cfg,
  input  logic [7:0]              cmd,
  input  logic [31:0]             addr,
  input  logic [8*DATA_BYTES-1:0] wdata,
  input  logic [3:0]              io_in,
  output logic                    sclk,
  output logic [3:0]              io_out,
  output logic [3:0]              io_oe,
  output logic                    done,
  output logic [8*DATA_BYTES-1:0] rx_data,
  output phase_e                  cur_phase,
  output logic                    active
);
  localparam int          BI_W = $clog2(DATA_BYTES);
  localparam logic [4:0]  MAXD = 5'(DATA_BYTES);

  phase_e     ph, first_ph, next_ph;
  logic [4:0] bidx, len;
  logic [2:0] slot;
  logic       hi;
  logic [1:0] code;
  logic [3:0] nslots;
  logic [BI_W-1:0] bsel;
  logic [2:0] ashift;
  logic [7:0] tx_byte;
  logic       drive, last_slot, last_byte;
  logic       unused_cfg;

  assign unused_cfg = ^cfg[15:14];
  assign code      = phase_code(ph, cfg);
  assign len       = phase_len(ph, cfg, MAXD);
  assign nslots    = slots_of(code);
  assign first_ph  = find_phase(0, cfg, MAXD);
  assign next_ph   = find_phase(int'(ph) + 1, cfg, MAXD);
  assign bsel      = bidx[BI_W-1:0];
  assign ashift    = 3'(len - 5'd1 - bidx);
  assign last_slot = (slot == 3'(nslots - 4'd1));
  assign last_byte = (bidx == len - 5'd1);
  assign drive     = active && (ph == PH_CMD || ph == PH_ADDR || ph == PH_WR);

  always_comb begin
    case (ph)
      PH_CMD:  tx_byte = cmd;
      PH_ADDR: tx_byte = addr[{ashift[1:0], 3'b000} +: 8];
      PH_WR:   tx_byte = wdata[{bsel, 3'b000} +: 8];
      default: tx_byte = 8'd0;
    endcase
  end

  assign io_oe     = drive ? lane_mask(code) : 4'b0000;
  assign io_out    = drive ? lane_bits(tx_byte, code, slot) : 4'b0000;
  assign sclk      = hi;
  assign cur_phase = ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= PH_END;
      bidx    <= '0;
      slot    <= '0;
      hi      <= 1'b0;
      active  <= 1'b0;
      done    <= 1'b0;
      rx_data <= '0;
    end else begin
      done <= 1'b0;
      if (go) begin
        ph      <= first_ph;
        bidx    <= '0;
        slot    <= '0;
        hi      <= 1'b0;
        rx_data <= '0;
        active  <= (first_ph != PH_END);
        done    <= (first_ph == PH_END);
      end else if (active) begin
        if (!hi) begin
          hi <= 1'b1;
          if (ph == PH_RD)
            rx_data[{bsel, 3'b000} +: 8] <= rx_merge(rx_data[{bsel, 3'b000} +: 8], code, io_in);
        end else begin
          hi <= 1'b0;
          if (!last_slot) begin
            slot <= slot + 3'd1;
          end else begin
            slot <= '0;
            if (!last_byte) begin
              bidx <= bidx + 5'd1;
            end else begin
              bidx <= '0;
              ph   <= next_ph;
              if (next_ph == PH_END) begin
                active <= 1'b0;
                done   <= 1'b1;
              end
            end
          end
        end
      end
    end
  end

endmodule

// File: rtl/flash_xact_engine.sv
module flash_xact_engine
  import fxe_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int NUM_CS     = 4,
  parameter int DATA_BYTES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  output logic              sclk,
  output logic [NUM_CS-1:0] cs_n,
  output logic [3:0]        io_out,
  output logic [3:0]        io_oe,
  input  logic [3:0]        io_in
);
  localparam int CS_W = $clog2(NUM_CS);

  logic [28:0]             cfg;
  logic [7:0]              cmd;
  logic [31:0]             addr;
  logic [8*DATA_BYTES-1:0] wdata, rx_data;
  logic [CS_W-1:0]         cs_sel;
  logic                    cs_release, busy, go, start_req, rdy_flag, done;
  logic                    seq_act;
  phase_e                  seq_phase;
  logic                    start_while_busy;

  assign start_while_busy = start_req && busy;

  fxe_regs #(.ADDR_W(ADDR_W), .NUM_CS(NUM_CS), .DATA_BYTES(DATA_BYTES)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .done(done), .rx_data(rx_data),
    .cfg(cfg), .cmd(cmd), .addr(addr), .wdata(wdata), .cs_sel(cs_sel),
    .cs_release(cs_release), .busy(busy), .go(go), .start_req(start_req),
    .rdy_flag(rdy_flag), .irq(irq)
  );

  fxe_seq #(.DATA_BYTES(DATA_BYTES)) u_seq (
    .clk(clk), .rst_n(rst_n), .go(go), .cfg(cfg), .cmd(cmd), .addr(addr), .wdata(wdata),
    .io_in(io_in), .sclk(sclk), .io_out(io_out), .io_oe(io_oe), .done(done),
    .rx_data(rx_data), .cur_phase(seq_phase), .active(seq_act)
  );

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign cs_n[i] = !((cs_sel == CS_W'(i)) && (busy || !cs_release));
  end

endmodule

// File: rtl/fxe_chk.sv
module fxe_chk
  import fxe_pkg::*;
#(
  parameter int NUM_CS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              sclk,
  input logic [NUM_CS-1:0] cs_n,
  input logic [3:0]        io_oe,
  input phase_e            seq_phase,
  input logic              seq_act,
  input logic              rdy_flag,
  input logic              start_while_busy
);

  AST_ONE_CS: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n)); // R9

  AST_CS_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cs_n != {NUM_CS{1'b1}})); // R9

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_act |-> !sclk); // R5

  AST_SCLK_HALF_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_act && !sclk) |=> sclk); // R5

  AST_DONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!busy && rdy_flag)); // R2

  AST_NO_DRIVE_LISTEN: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_act && (seq_phase == PH_RD || seq_phase == PH_DUMMY)) |-> (io_oe == 4'b0000)); // R8

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (start_while_busy && !done) |=> busy); // R10

endmodule

bind flash_xact_engine fxe_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .sclk(sclk), .cs_n(cs_n),
  .io_oe(io_oe), .seq_phase(seq_phase), .seq_act(seq_act), .rdy_flag(rdy_flag),
  .start_while_busy(start_while_busy)
);

// File: tb/flash_xact_engine_tb.sv
module flash_xact_engine_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  wire  [31:0] bus_rdata;
  wire         irq, sclk;
  wire  [3:0]  cs_n, io_out, io_oe;
  logic [3:0]  io_in;

  int errors = 0;
  int checks = 0;

  always #(CLK_P/2) clk = ~clk;

  flash_xact_engine u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .sclk(sclk), .cs_n(cs_n),
    .io_out(io_out), .io_oe(io_oe), .io_in(io_in)
  );

  // Flash model: records each rising SCLK edge, returns a position-derived pattern.
  int         edge_total = 0;
  logic [3:0] cap_out [1024];
  logic [3:0] cap_oe  [1024];
  logic [3:0] cap_cs  [1024];
  time        rise_t  [1024];

  function automatic logic [3:0] pat(input int k);
    return 4'((k * 7) ^ (k >> 3) ^ 5);
  endfunction

  assign io_in = pat(edge_total);

  always @(posedge sclk) begin
    cap_out[edge_total % 1024] = io_out;
    cap_oe[edge_total % 1024]  = io_oe;
    cap_cs[edge_total % 1024]  = cs_n;
    rise_t[edge_total % 1024]  = $time;
    edge_total = edge_total + 1;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  // Current run description
  logic [31:0] cur_cfg, cur_addr;
  logic [7:0]  cur_cmd;
  logic [7:0]  cur_wb [16];
  int          cur_sel, cur_base;
  logic [31:0] prev_rd [4];

  function automatic int lw(input logic [1:0] c);
    return (c == 2'd0) ? 1 : (c == 2'd1) ? 2 : 4;
  endfunction

  function automatic int blen(input int p);
    int n;
    case (p)
      0: n = int'(cur_cfg[10]);
      1: n = (cur_cfg[13:11] > 4) ? 4 : int'(cur_cfg[13:11]);
      2: n = int'(cur_cfg[23:21]);
      3: n = (cur_cfg[20:16] > 16) ? 16 : int'(cur_cfg[20:16]);
      default: n = (cur_cfg[28:24] > 16) ? 16 : int'(cur_cfg[28:24]);
    endcase
    return n;
  endfunction

  function automatic logic [1:0] bcode(input int p);
    case (p)
      0: return cur_cfg[1:0];
      1: return cur_cfg[3:2];
      2: return cur_cfg[7:6];
      3: return cur_cfg[5:4];
      default: return cur_cfg[9:8];
    endcase
  endfunction

  task automatic start_run(input logic [31:0] cfg, input logic [7:0] cmd, input logic [31:0] addr,
                           input int seed, input int sel, input bit hold);
    cur_cfg = cfg; cur_cmd = cmd; cur_addr = addr; cur_sel = sel;
    for (int k = 0; k < 16; k++) cur_wb[k] = 8'(seed * 17 + k * 29 + 3);
    for (int i = 0; i < 4; i++)
      wr(8'h20 + 8'(4 * i), {cur_wb[4*i+3], cur_wb[4*i+2], cur_wb[4*i+1], cur_wb[4*i]});
    wr(8'h08, cfg);
    wr(8'h10, {24'd0, cmd});
    wr(8'h14, addr);
    cur_base = edge_total;
    wr(8'h0C, 32'h1 | (32'(sel) << 8) | (hold ? 32'h0 : 32'h0001_0000));
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    int n;
    n = 0;
    v = 32'h1;
    while (v[0] && n < 3000) begin
      rd(8'h0C, v);
      n++;
    end
    chk(!v[0], "R2 run completes", v, 32'h0);
  endtask

  task automatic verify();
    int idx, bad, badcs, badp, w, nb, k;
    logic [7:0] v, acc;
    logic [3:0] eo, ee, lin;
    logic [7:0] rb [16];
    logic [31:0] got;
    idx = 0; bad = 0; badcs = 0; badp = 0;
    for (int b = 0; b < 16; b++) rb[b] = 8'd0;
    for (int p = 0; p < 5; p++) begin
      nb = blen(p);
      w  = lw(bcode(p));
      for (int b = 0; b < nb; b++) begin
        case (p)
          0: v = cur_cmd;
          1: v = 8'(cur_addr >> (8 * (nb - 1 - b)));
          3: v = cur_wb[b];
          default: v = 8'd0;
        endcase
        acc = 8'd0;
        for (int s = 0; s < 8 / w; s++) begin
          k = (cur_base + idx) % 1024;
          if (p == 0 || p == 1 || p == 3) begin
            ee = 4'((1 << w) - 1);
            eo = 4'((v >> (8 - w * (s + 1))) & ((1 << w) - 1));
          end else begin
            ee = 4'd0;
            eo = 4'd0;
          end
          if (cap_out[k] != eo || cap_oe[k] != ee) bad++;
          if (cap_cs[k] != ~(4'b0001 << cur_sel)) badcs++;
          if (idx > 0 && rise_t[k] - rise_t[(cur_base + idx - 1) % 1024] != 2 * CLK_P) badp++;
          lin = pat(cur_base + idx);
          if (w == 1)      acc = {acc[6:0], lin[1]};
          else if (w == 2) acc = {acc[5:0], lin[1:0]};
          else             acc = {acc[3:0], lin};
          idx++;
        end
        if (p == 4) rb[b] = acc;
      end
    end
    chk(edge_total - cur_base == idx, "R3 SCLK edge count", 32'(edge_total - cur_base), 32'(idx));
    chk(bad == 0, "R4 R6 R8 lane stream mismatches", 32'(bad), 32'd0);
    chk(badcs == 0, "R9 chip select during run", 32'(badcs), 32'd0);
    chk(badp == 0, "R5 SCLK period", 32'(badp), 32'd0);
    for (int i = 0; i < 4; i++) begin
      rd(8'h30 + 8'(4 * i), got);
      prev_rd[i] = {rb[4*i+3], rb[4*i+2], rb[4*i+1], rb[4*i]};
      chk(got == prev_rd[i], "R7 received word", got, prev_rd[i]);
    end
    rd(8'h0C, got);
    chk(got[24] == 1'b1, "R2 ready set", got, 32'h0100_0000);
  endtask

  initial begin
    #(CLK_P * 190000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v, cfg;
    int idx;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cs_n == 4'hF, "R1 cs_n at reset", 32'(cs_n), 32'hF);
    chk(sclk == 1'b0, "R1 sclk at reset", 32'(sclk), 32'h0);
    chk(io_oe == 4'h0, "R1 io_oe at reset", 32'(io_oe), 32'h0);
    chk(irq == 1'b0, "R1 irq at reset", 32'(irq), 32'h0);
    rd(8'h0C, v);
    chk(v == 32'h0001_0000, "R1 control at reset", v, 32'h0001_0000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3 empty run: no opcode, no bytes
    start_run(32'h0, 8'h00, 32'h0, 0, 0, 1'b0);
    wait_idle();
    verify();

    // Sweep lane codes, address counts and data counts
    idx = 0;
    for (int w = 0; w < 4; w++) begin
      for (int ac = 0; ac < 6; ac++) begin
        for (int pr = 0; pr < 5; pr++) begin
          int wn, rn, dn, en;
          case (pr)
            0: begin wn = 0;  rn = 0;  end
            1: begin wn = 1;  rn = 3;  end
            2: begin wn = 7;  rn = 16; end
            3: begin wn = 16; rn = 2;  end
            default: begin wn = 31; rn = 20; end
          endcase
          dn = (ac + w + pr) % 8;
          en = (((w + ac + pr) % 4) != 3) ? 1 : 0;
          cfg = 32'(w) | (32'((w + 1) % 4) << 2) | (32'((w + 2) % 4) << 4)
              | (32'((w + 3) % 4) << 6) | (32'((w + 1 + pr) % 4) << 8)
              | (32'(en) << 10) | (32'(ac) << 11) | (32'(wn) << 16)
              | (32'(dn) << 21) | (32'(rn) << 24);
          start_run(cfg, 8'hA5 ^ 8'(idx), 32'h1234_5678 + 32'(idx) * 32'h0101_0101,
                    idx, idx % 4, 1'b0);
          wait_idle();
          verify();
          idx++;
        end
      end
    end

    // R12 interrupt follows ready and enable; R2 ready cleared by write-one
    wr(8'h0C, 32'h0201_0000);
    @(negedge clk);
    chk(irq == 1'b1, "R12 irq with ready and enable", 32'(irq), 32'h1);
    wr(8'h0C, 32'h0301_0000);
    @(negedge clk);
    chk(irq == 1'b0, "R12 irq after ready cleared", 32'(irq), 32'h0);
    rd(8'h0C, v);
    chk(v == 32'h0201_0000, "R2 ready cleared by write", v, 32'h0201_0000);
    wr(8'h0C, 32'h0001_0000);

    // R9 chip-select hold across runs, then release
    start_run(32'h0300_1C00 | 32'h0000_0000, 8'h02, 32'h00AB_CDEF, 7, 2, 1'b1);
    wait_idle();
    verify();
    chk(cs_n == 4'b1011, "R9 chip select held after run", 32'(cs_n), 32'hB);
    wr(8'h0C, 32'h0001_0200);
    @(negedge clk);
    chk(cs_n == 4'hF, "R9 chip select released", 32'(cs_n), 32'hF);

    // R10 / R11 writes and start during a busy run
    cfg = 32'h1010_2400; // opcode, 4 address bytes, 16 send, 16 receive, single lane
    start_run(cfg, 8'h6B, 32'hDEAD_BEEF, 3, 1, 1'b0);
    wr(8'h08, 32'h0);
    wr(8'h10, 32'h0);
    wr(8'h14, 32'h0);
    wr(8'h20, 32'h0);
    wr(8'h0C, 32'h0001_0301);
    rd(8'h30, v);
    chk(v == prev_rd[0], "R11 received word stable while busy", v, prev_rd[0]);
    rd(8'h0C, v);
    chk(v[0] == 1'b1, "R10 still busy after ignored start", v, 32'h1);
    wait_idle();
    rd(8'h08, v);
    chk(v == cfg, "R10 config write ignored while busy", v, cfg);
    rd(8'h0C, v);
    chk(v[9:8] == 2'd1, "R10 select write ignored while busy", 32'(v[9:8]), 32'h1);
    verify();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule